// File: doc/BRIEF.md
# Cache Injection Window Table

This block sits beside a private cache in a bus-based multiprocessor. The local processor opens address windows over shared data it expects to consume. The block watches every snooped bus transfer. When a read reply to another cache's miss, or a producer's update, carries a block that falls inside an open window, the block hands that data to the local cache so it can be installed without a miss. A later local load to that block then hits.

A window is opened in two steps. A set-low command stages the lower bound. A set-high command then writes the upper bound and claims a free table entry. A close command names a lower bound and removes every window that starts there. All addresses at the ports are block numbers, so matching works at block granularity.

Injections leave through a valid/ready stream with a single holding register. While an injection is offered and not taken (`inj_valid` high, `inj_ready` low), the offered address, data and state stay fixed. Any matching transfer that arrives in that time is dropped, because injection is only a hint and the bus is never stalled. The command and snoop inputs have no back-pressure.

Top module: `inj_window_table`

## Requirements
- R1: After reset the table holds no windows, `inj_valid` is 0 and `win_overflow` is 0, so no snooped transfer is injected.
- R2: A set-low command (`cmd_op`=0) stages a lower bound. A following set-high command (`cmd_op`=1) opens a window from the staged bound to its own address. The window takes part in matching from the cycle after the set-high command. `cmd_op`=3 does nothing.
- R3: A snooped block matches when, for some open window, low <= block <= high. Both bounds are inclusive, and a window whose high bound is below its low bound matches nothing.
- R4: Only snoop kinds read-reply (`snoop_kind`=1) and update (`snoop_kind`=2) can inject. Kinds 0 and 3 never do.
- R5: An eligible matching transfer sampled at a clock edge appears one cycle later with `inj_valid`=1, its block in `inj_addr`, its data in `inj_data`, and `inj_state`=2'b01 (Shared).
- R6: A transfer whose `snoop_src` equals the parameter `NODE_ID` is never injected.
- R7: A transfer that arrives with `local_valid`=1 (the local cache already holds the block valid) is never injected.
- R8: A close command (`cmd_op`=2) removes every open window whose low bound equals `cmd_blk`. A close that matches no low bound leaves all windows unchanged.
- R9: A set-high command issued while all `ENTRIES` windows are open is ignored. `win_overflow` is 1 in the following cycle only.
- R10: While `inj_valid`=1 and `inj_ready`=0, the outputs `inj_addr` and `inj_data` hold, and matching transfers in those cycles are dropped. When a transfer is taken and no new match arrives, `inj_valid` falls in the next cycle.
- R11: An entry freed by a close can be claimed again by a later set-high command, without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Window command strobe |
| cmd_op | input | 2 | 0 set-low, 1 set-high/open, 2 close, 3 no-op |
| cmd_blk | input | BLK_AW | Block address operand of the command |
| snoop_valid | input | 1 | A bus transfer is observed this cycle |
| snoop_kind | input | 2 | 0 other, 1 read reply, 2 update, 3 other |
| snoop_src | input | NODE_W | Node that issued the transfer |
| snoop_blk | input | BLK_AW | Block address of the transfer |
| snoop_data | input | DATA_W | Block data on the bus |
| local_valid | input | 1 | Local cache holds `snoop_blk` in a valid state |
| inj_valid | output | 1 | Injection offered |
| inj_ready | input | 1 | Cache accepts the injection |
| inj_addr | output | BLK_AW | Block to install |
| inj_data | output | DATA_W | Data to install |
| inj_state | output | 2 | State to install, always Shared (2'b01) |
| win_overflow | output | 1 | One-cycle pulse: an open was refused, the table is full |

## Verification
A wrong bound, a lost valid bit or a wrong free-slot choice in the table stays hidden until a snoop hits the region it affects. It then shows as an injection that is missing or unexpected one cycle after that snoop. A wrong count of open windows shows at the next open command, as an overflow pulse that is missing or spurious in the following cycle. Errors in the output register show at once at the stream port: a payload that moves during a stall, or a valid that does not fall after a handshake.

// File: rtl/inj_pkg.sv
package inj_pkg;
  typedef enum logic [1:0] {
    CMD_SET_LO = 2'd0,
    CMD_SET_HI = 2'd1,
    CMD_CLOSE  = 2'd2,
    CMD_NOP    = 2'd3
  } win_cmd_e;

  typedef enum logic [1:0] {
    SN_PLAIN  = 2'd0,
    SN_RDREP  = 2'd1,
    SN_UPDATE = 2'd2,
    SN_OTHER  = 2'd3
  } snoop_kind_e;

  localparam logic [1:0] LINE_SHARED = 2'b01;
endpackage

// File: rtl/inj_window_store.sv
module inj_window_store
  import inj_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int BLK_AW  = 27
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_valid,
  input  logic [1:0]                       cmd_op,
  input  logic [BLK_AW-1:0]                cmd_blk,
  output logic [ENTRIES-1:0]               win_v,
  output logic [ENTRIES-1:0][BLK_AW-1:0]   win_lo,
  output logic [ENTRIES-1:0][BLK_AW-1:0]   win_hi,
  output logic                             ovf_q
);
  logic [BLK_AW-1:0]  pend_lo;
  logic [ENTRIES-1:0] alloc_oh;
  logic               full;
  logic               do_open;
  logic               do_close;
  logic               do_stage;

  assign full     = &win_v;
  assign do_stage = cmd_valid && (cmd_op == CMD_SET_LO);
  assign do_open  = cmd_valid && (cmd_op == CMD_SET_HI) && !full;
  assign do_close = cmd_valid && (cmd_op == CMD_CLOSE);

  // lowest free slot, one-hot
  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!win_v[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_lo <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (do_stage) pend_lo <= cmd_blk;
      ovf_q <= cmd_valid && (cmd_op == CMD_SET_HI) && full;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_v[g]  <= 1'b0;
        win_lo[g] <= '0;
        win_hi[g] <= '0;
      end else if (do_close && win_v[g] && (win_lo[g] == cmd_blk)) begin
        win_v[g] <= 1'b0;
      end else if (do_open && alloc_oh[g]) begin
        win_v[g]  <= 1'b1;
        win_lo[g] <= pend_lo;
        win_hi[g] <= cmd_blk;
      end
    end

    // R8: a close naming this slot's low bound frees it
    a_r8_close_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (do_close && win_v[g] && (win_lo[g] == cmd_blk)) |=> !win_v[g]);
  end

  // R9: overflow pulse only follows a refused open
  a_r9_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(cmd_valid && (cmd_op == CMD_SET_HI) && (&win_v)));

  // R9: a refused open leaves the valid set untouched
  a_r9_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == CMD_SET_HI) && (&win_v)) |=> (&win_v));
endmodule

// File: rtl/inj_match.sv
module inj_match #(
  parameter int ENTRIES = 4,
  parameter int BLK_AW  = 27
) (
  input  logic [ENTRIES-1:0]             win_v,
  input  logic [ENTRIES-1:0][BLK_AW-1:0] win_lo,
  input  logic [ENTRIES-1:0][BLK_AW-1:0] win_hi,
  input  logic [BLK_AW-1:0]              probe_blk,
  output logic                           hit
);
  logic [ENTRIES-1:0] slot_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign slot_hit[g] = win_v[g] &&
                         (probe_blk >= win_lo[g]) &&
                         (probe_blk <= win_hi[g]);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/inj_out_stage.sv
module inj_out_stage
  import inj_pkg::*;
#(
  parameter int BLK_AW = 27,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [BLK_AW-1:0] load_blk,
  input  logic [DATA_W-1:0] load_data,
  output logic              inj_valid,
  input  logic              inj_ready,
  output logic [BLK_AW-1:0] inj_addr,
  output logic [DATA_W-1:0] inj_data,
  output logic [1:0]        inj_state
);
  logic accept;

  assign accept    = !inj_valid || inj_ready;
  assign inj_state = LINE_SHARED;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inj_valid <= 1'b0;
      inj_addr  <= '0;
      inj_data  <= '0;
    end else if (accept) begin
      inj_valid <= load_req;
      if (load_req) begin
        inj_addr <= load_blk;
        inj_data <= load_data;
      end
    end
  end

  // R10: stalled payload holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_ready) |=> (inj_valid && $stable(inj_addr) && $stable(inj_data)));

  // R5: an accepted request is offered on the next cycle
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && (!inj_valid || inj_ready)) |=> (inj_valid && (inj_addr == $past(load_blk))));

  // R10: a taken transfer with no new request drops valid
  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && inj_ready && !load_req) |=> !inj_valid);
endmodule

// File: rtl/inj_window_table.sv
module inj_window_table
  import inj_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int BLK_AW  = 27,
  parameter int DATA_W  = 64,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BLK_AW-1:0] cmd_blk,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_kind,
  input  logic [NODE_W-1:0] snoop_src,
  input  logic [BLK_AW-1:0] snoop_blk,
  input  logic [DATA_W-1:0] snoop_data,
  input  logic              local_valid,
  output logic              inj_valid,
  input  logic              inj_ready,
  output logic [BLK_AW-1:0] inj_addr,
  output logic [DATA_W-1:0] inj_data,
  output logic [1:0]        inj_state,
  output logic              win_overflow
);
  localparam logic [NODE_W-1:0] SELF = NODE_W'(NODE_ID);

  logic [ENTRIES-1:0]             win_v;
  logic [ENTRIES-1:0][BLK_AW-1:0] win_lo;
  logic [ENTRIES-1:0][BLK_AW-1:0] win_hi;
  logic                           win_hit;
  logic                           kind_ok;
  logic                           from_peer;
  logic                           eligible;

  inj_window_store #(.ENTRIES(ENTRIES), .BLK_AW(BLK_AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_blk   (cmd_blk),
    .win_v     (win_v),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .ovf_q     (win_overflow)
  );

  inj_match #(.ENTRIES(ENTRIES), .BLK_AW(BLK_AW)) u_match (
    .win_v     (win_v),
    .win_lo    (win_lo),
    .win_hi    (win_hi),
    .probe_blk (snoop_blk),
    .hit       (win_hit)
  );

  assign kind_ok   = (snoop_kind == SN_RDREP) || (snoop_kind == SN_UPDATE);
  assign from_peer = (snoop_src != SELF);
  assign eligible  = snoop_valid && kind_ok && from_peer && !local_valid && win_hit;

  inj_out_stage #(.BLK_AW(BLK_AW), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (eligible),
    .load_blk  (snoop_blk),
    .load_data (snoop_data),
    .inj_valid (inj_valid),
    .inj_ready (inj_ready),
    .inj_addr  (inj_addr),
    .inj_data  (inj_data),
    .inj_state (inj_state)
  );

  // R6 / R7: own or already-present traffic never produces a new offer
  a_r6_r7_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && ((snoop_src == SELF) || local_valid) && !(inj_valid && !inj_ready))
      |=> !inj_valid);

  // R4: non-injecting kinds never produce a new offer
  a_r4_kind_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (!(snoop_valid && kind_ok) && !(inj_valid && !inj_ready)) |=> !inj_valid);
endmodule

// File: tb/sim_inj_window_table.sv
module sim_inj_window_table;
  localparam int ENT = 4;
  localparam int AW  = 27;
  localparam int DW  = 64;
  localparam int NW  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_blk;
  logic          snoop_valid;
  logic [1:0]    snoop_kind;
  logic [NW-1:0] snoop_src;
  logic [AW-1:0] snoop_blk;
  logic [DW-1:0] snoop_data;
  logic          local_valid;
  logic          inj_valid;
  logic          inj_ready;
  logic [AW-1:0] inj_addr;
  logic [DW-1:0] inj_data;
  logic [1:0]    inj_state;
  logic          win_overflow;

  always #4 clk = ~clk;

  inj_window_table #(.ENTRIES(ENT), .BLK_AW(AW), .DATA_W(DW), .NODE_W(NW), .NODE_ID(0)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .snoop_valid(snoop_valid), .snoop_kind(snoop_kind), .snoop_src(snoop_src),
    .snoop_blk(snoop_blk), .snoop_data(snoop_data), .local_valid(local_valid),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_addr(inj_addr),
    .inj_data(inj_data), .inj_state(inj_state), .win_overflow(win_overflow));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  bit            m_v [ENT];
  logic [AW-1:0] m_lo[ENT];
  logic [AW-1:0] m_hi[ENT];
  logic [AW-1:0] m_pend;
  bit            m_iv, m_ov;
  logic [AW-1:0] m_ia;
  logic [DW-1:0] m_id;

  function automatic bit ref_hit(input logic [AW-1:0] b);
    for (int i = 0; i < ENT; i++)
      if (m_v[i] && b >= m_lo[i] && b <= m_hi[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit ref_full();
    for (int i = 0; i < ENT; i++) if (!m_v[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic ref_step();
    bit elig, placed;
    elig = snoop_valid && (snoop_kind == 2'd1 || snoop_kind == 2'd2) &&
           snoop_src != 0 && !local_valid && ref_hit(snoop_blk);
    if (!m_iv || inj_ready) begin
      m_iv = elig;
      if (elig) begin m_ia = snoop_blk; m_id = snoop_data; end
    end
    m_ov = cmd_valid && cmd_op == 2'd1 && ref_full();
    if (cmd_valid) begin
      case (cmd_op)
        2'd0: m_pend = cmd_blk;
        2'd1: if (!ref_full()) begin
                placed = 1'b0;
                for (int i = 0; i < ENT; i++)
                  if (!m_v[i] && !placed) begin
                    m_v[i] = 1'b1; m_lo[i] = m_pend; m_hi[i] = cmd_blk; placed = 1'b1;
                  end
              end
        2'd2: for (int i = 0; i < ENT; i++) if (m_v[i] && m_lo[i] == cmd_blk) m_v[i] = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: model, edge, compare at the falling edge
  task automatic tick(input string tag);
    ref_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "inj_valid", 64'(inj_valid), 64'(m_iv));
    chk(tag, "win_overflow", 64'(win_overflow), 64'(m_ov));
    if (m_iv) begin
      chk(tag, "inj_addr", 64'(inj_addr), 64'(m_ia));
      chk(tag, "inj_data", 64'(inj_data), m_id);
      chk("R5", "inj_state", 64'(inj_state), 64'h1);
    end
    cmd_valid = 1'b0; snoop_valid = 1'b0; snoop_src = 2'd1; local_valid = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [AW-1:0] b, input string tag);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = b;
    tick(tag);
  endtask

  task automatic snoop(input logic [1:0] k, input logic [AW-1:0] b, input logic [DW-1:0] d, input string tag);
    snoop_valid = 1'b1; snoop_kind = k; snoop_blk = b; snoop_data = d;
    tick(tag);
  endtask

  task automatic open_win(input logic [AW-1:0] lo, input logic [AW-1:0] hi, input string tag);
    cmd(2'd0, lo, tag);
    cmd(2'd1, hi, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd3; cmd_blk = '0;
    snoop_valid = 1'b0; snoop_kind = 2'd0; snoop_src = 2'd1; snoop_blk = '0;
    snoop_data = '0; local_valid = 1'b0; inj_ready = 1'b1;
    for (int i = 0; i < ENT; i++) begin m_v[i] = 1'b0; m_lo[i] = '0; m_hi[i] = '0; end
    m_pend = '0; m_iv = 1'b0; m_ov = 1'b0; m_ia = '0; m_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "inj_valid after reset", 64'(inj_valid), 64'h0);
    chk("R1", "overflow after reset", 64'(win_overflow), 64'h0);
    snoop(2'd1, 27'd15, 64'hA1, "R1");          // empty table: nothing

    open_win(27'd10, 27'd20, "R2");
    cmd(2'd3, 27'd99, "R2");                    // no-op leaves table alone
    snoop(2'd1, 27'd10, 64'hB0, "R2");
    chk("R2", "open window injects low bound", 64'(inj_valid), 64'h1);
    snoop(2'd1, 27'd20, 64'hB1, "R3");
    chk("R3", "inclusive high bound", 64'(inj_addr), 64'd20);
    snoop(2'd1, 27'd21, 64'hB2, "R3");
    chk("R3", "just above window", 64'(inj_valid), 64'h0);
    snoop(2'd2, 27'd9, 64'hB3, "R3");
    snoop(2'd2, 27'd15, 64'hC0, "R4");
    chk("R4", "update kind injects", 64'(inj_data), 64'hC0);
    snoop(2'd0, 27'd15, 64'hC1, "R4");
    chk("R4", "kind 0 ignored", 64'(inj_valid), 64'h0);
    snoop(2'd3, 27'd15, 64'hC2, "R4");
    snoop_src = 2'd0;
    snoop(2'd1, 27'd15, 64'hD0, "R6");
    chk("R6", "own transfer ignored", 64'(inj_valid), 64'h0);
    local_valid = 1'b1;
    snoop(2'd1, 27'd15, 64'hD1, "R7");
    chk("R7", "present block ignored", 64'(inj_valid), 64'h0);

    inj_ready = 1'b0;
    snoop(2'd1, 27'd12, 64'hE0, "R10");
    snoop(2'd1, 27'd13, 64'hE1, "R10");
    chk("R10", "stalled payload holds", 64'(inj_data), 64'hE0);
    inj_ready = 1'b1;
    tick("R10");
    chk("R10", "valid falls after take", 64'(inj_valid), 64'h0);

    open_win(27'd30, 27'd31, "R9");
    open_win(27'd40, 27'd41, "R9");
    open_win(27'd50, 27'd51, "R9");
    open_win(27'd60, 27'd61, "R9");
    chk("R9", "refused open pulses overflow", 64'(win_overflow), 64'h1);
    snoop(2'd1, 27'd60, 64'hF0, "R9");
    chk("R9", "refused window inert, pulse over", 64'(inj_valid) | 64'(win_overflow), 64'h0);

    cmd(2'd2, 27'd11, "R8");
    snoop(2'd1, 27'd15, 64'hF1, "R8");
    chk("R8", "non-matching close keeps window", 64'(inj_valid), 64'h1);
    cmd(2'd2, 27'd10, "R8");
    snoop(2'd1, 27'd15, 64'hF2, "R8");
    chk("R8", "closed window inert", 64'(inj_valid), 64'h0);
    open_win(27'd60, 27'd61, "R11");
    chk("R11", "reuse without overflow", 64'(win_overflow), 64'h0);
    snoop(2'd2, 27'd61, 64'hF3, "R11");
    chk("R11", "reused slot matches", 64'(inj_valid), 64'h1);

    // random traffic against the reference
    for (int n = 0; n < 4000; n++) begin
      inj_ready   = ($urandom % 4) != 0;
      local_valid = ($urandom % 8) == 0;
      snoop_src   = NW'($urandom);
      if (($urandom % 6) == 0) begin
        cmd_valid = 1'b1; cmd_op = 2'($urandom); cmd_blk = AW'($urandom % 64);
      end
      if (($urandom % 3) != 0) begin
        snoop_valid = 1'b1; snoop_kind = 2'($urandom);
        snoop_blk = AW'($urandom % 64); snoop_data = {$urandom, $urandom};
      end
      tick("R3");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule